// File: doc/BRIEF.md
# Register-Programmed Serial Peripheral Master

This block is a single-channel SPI master for one character at a time. Software drives it through a small 32-bit register window. It first programs a mode word while the block is disabled: clock polarity, clock phase, bit order, loopback, character length and a two-stage bit-clock prescaler. It then writes a character to the transmit register. The block shifts that character out on `sclk`/`mosi` and samples `miso` at the same time. When the character is done, it latches the received bits into the receive register and raises two events.

The two events are receive-not-empty and transmit-not-full. Software acknowledges each one by writing a 1 to its bit. A mask register selects which events drive the interrupt output. Chip selects come from separate general-purpose pins and are not part of this block. There is one transmit holding register and one receive holding register, and no queue.

Top module: `spi_regmaster`

## Requirements
- R1: After reset every register reads zero, `sclk` and `mosi` are low and `irq` is low.
- R2: Registers sit at byte offsets 0x20 mode, 0x24 event, 0x28 mask, 0x2C command, 0x30 transmit and 0x34 receive. A read returns data on `bus_rdata` one cycle after `bus_rd`. The mode register keeps bits 30:16 only. Mask and event use bits 9:8. The command register and all other offsets read zero.
- R3: Mode bits are 30 loopback, 29 clock idles high, 28 data changes on the leading edge, 27 extra divide-by-16, 26 MSB first (clear means LSB first), 25 master, and 24 enable. A mode write is taken in full only while enable is clear. While enable is set, a write changes only bit 24.
- R4: A transmit write starts a character only when enable and master are set and no character is in flight. Any other transmit write is dropped, and the transmit register keeps its old value.
- R5: Mode bits 19:16 hold PM. One half period of `sclk` lasts 2·(PM+1) system clocks, or 32·(PM+1) when bit 27 is set. The first edge comes one half period after the start is registered.
- R6: When idle, `sclk` sits at the level given by bit 29. With bit 28 clear, the first bit is on `mosi` from the start, bits are sampled on odd edges, and `mosi` changes on even edges. With bit 28 set, `mosi` changes on odd edges and bits are sampled on even edges.
- R7: Mode bits 23:20 hold the character length minus one, for lengths 4 to 16. The value 0 selects 32 bits. The character is taken from the low bits of the transmit register. The received character is right-justified, with zeros above it.
- R8: With bit 30 set, the receiver samples the block's own `mosi` instead of `miso`.
- R9: Event bit 9 means receive-not-empty and bit 8 means transmit-not-full. Bit 8 clears when a character starts. Both bits set in the cycle the character ends. Writing 1 to a bit clears it. Reading the receive register clears nothing.
- R10: `irq` is a register holding the OR of (event AND mask). It follows the event and mask registers one cycle later.
- R11: A mode write that clears enable during a character stops it at once. `sclk` returns to its idle level, no event is raised and the receive register is unchanged.
- R12: Writing command bit 23 while enabled, master and idle sends the current transmit register again.
- R13: No overrun is flagged. A new character overwrites the receive register even when bit 9 is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| sclk | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Registered interrupt request |

## Verification
A start takes effect on the clock edge that accepts the write. The first `sclk` edge follows H cycles later, where H is the half period. The final edge, the end of busy, the new receive data and both events all land together, 2·N·H cycles after the start. `irq` follows one further cycle later, and read data follows one cycle after the read strobe. The reference model in the bench counts cycles since the start with integers and compares `sclk`, `mosi`, `irq` and read data after every edge. It drives `miso` from the number of edges seen so far. Separate checks probe the exact first-edge cycle for a fast prescale and for a divide-by-16 prescale.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned PM_W    = 4;
  localparam int unsigned LCODE_W = 4;

  localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_EVENT = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_TX    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_RX    = 8'h34;

  localparam int unsigned MB_LOOP   = 30;
  localparam int unsigned MB_CPOL   = 29;
  localparam int unsigned MB_CPHA   = 28;
  localparam int unsigned MB_DIV16  = 27;
  localparam int unsigned MB_MSB    = 26;
  localparam int unsigned MB_MASTER = 25;
  localparam int unsigned MB_EN     = 24;
  localparam int unsigned LEN_LO    = 20;
  localparam int unsigned PM_LO     = 16;

  localparam int unsigned EV_RNE = 9;
  localparam int unsigned EV_TNF = 8;
  localparam int unsigned CMD_GO = 23;

  localparam logic [WORD_W-1:0] MODE_KEEP = 32'h7FFF_0000;

  // number of bits in a character for a given length code
  function automatic logic [$clog2(WORD_W):0] char_bits(input logic [LCODE_W-1:0] code);
    logic [$clog2(WORD_W):0] n;
    if (code == '0) n = ($clog2(WORD_W)+1)'(WORD_W);
    else            n = ($clog2(WORD_W)+1)'(code) + 1'b1;
    return n;
  endfunction
endpackage

// File: rtl/spi_rm_baud.sv
module spi_rm_baud #(
  parameter int unsigned PMW      = 4,
  parameter int unsigned FAST_SH  = 1,
  parameter int unsigned SLOW_SH  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [PMW-1:0] pm,
  input  logic           slow,
  output logic           tick
);
  localparam int unsigned CNT_W = PMW + 1 + SLOW_SH;

  logic [CNT_W-1:0] cnt_q, cnt_d, half;
  logic [PMW:0]     pm_inc;

  always_comb begin
    pm_inc = {1'b0, pm} + 1'b1;
    half   = slow ? (CNT_W'(pm_inc) << SLOW_SH) : (CNT_W'(pm_inc) << FAST_SH);
    tick   = run && (cnt_q == half - 1'b1);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_rm_shifter.sv
module spi_rm_shifter #(
  parameter int unsigned W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   stop,
  input  logic                   tick,
  input  logic [W-1:0]           start_word,
  input  logic [$clog2(W):0]     nbits,
  input  logic                   cpol,
  input  logic                   cpha,
  input  logic                   lsb_first,
  input  logic                   loop_en,
  input  logic                   miso,
  output logic                   busy,
  output logic                   sclk_out,
  output logic                   mosi_out,
  output logic                   done,
  output logic [W-1:0]           rx_word
);
  localparam int unsigned IDX_W  = $clog2(W);
  localparam int unsigned LEN_W  = IDX_W + 1;
  localparam int unsigned EDGE_W = IDX_W + 2;

  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic              mosi_q, mosi_d;
  logic [EDGE_W-1:0] edge_q, edge_d, edge_k;
  logic [W-1:0]      acc_q, acc_d;
  logic [W-1:0]      word_q, word_d;
  logic [IDX_W-1:0]  j;
  logic              samp, last;

  function automatic logic [IDX_W-1:0] slot(input logic [IDX_W-1:0] idx,
                                             input logic lsb,
                                             input logic [LEN_W-1:0] n);
    logic [LEN_W-1:0] t;
    t = n - 1'b1 - {1'b0, idx};
    return lsb ? idx : t[IDX_W-1:0];
  endfunction

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    mosi_d = mosi_q;
    edge_d = edge_q;
    acc_d  = acc_q;
    word_d = word_q;
    done   = 1'b0;
    edge_k = edge_q + 1'b1;
    j      = edge_q[IDX_W:1];
    samp   = loop_en ? mosi_q : miso;
    last   = (edge_k == {nbits, 1'b0});
    if (stop) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      sclk_d = cpol;
      edge_d = '0;
      acc_d  = '0;
      word_d = start_word;
      if (!cpha) mosi_d = start_word[slot('0, lsb_first, nbits)];
    end else if (busy_q && tick) begin
      sclk_d = ~sclk_q;
      edge_d = edge_k;
      if (edge_k[0]) begin
        if (cpha) mosi_d = word_q[slot(j, lsb_first, nbits)];
        else      acc_d[slot(j, lsb_first, nbits)] = samp;
      end else begin
        if (cpha)       acc_d[slot(j, lsb_first, nbits)] = samp;
        else if (!last) mosi_d = word_q[slot(j + 1'b1, lsb_first, nbits)];
      end
      if (last) begin
        busy_d = 1'b0;
        done   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      edge_q <= '0;
      acc_q  <= '0;
      word_q <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
      edge_q <= edge_d;
      acc_q  <= acc_d;
      if (start) word_q <= word_d;
    end
  end

  assign busy     = busy_q;
  assign sclk_out = busy_q ? sclk_q : cpol;
  assign mosi_out = mosi_q;
  assign rx_word  = acc_d;
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_rm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  localparam int unsigned NB_W = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] mode_q, mode_d;
  logic [WORD_W-1:0] tx_q, rx_q, rd_d, rdata_q, go_word;
  logic              ev_rne_q, ev_rne_d, ev_tnf_q, ev_tnf_d;
  logic [1:0]        mask_q;
  logic              irq_q, irq_d;
  logic              wr_mode, wr_event, wr_mask, wr_cmd, wr_tx;
  logic              can_go, go, stop, busy, done, tick;
  logic [WORD_W-1:0] rx_word;
  logic [NB_W-1:0]   nbits;

  always_comb begin
    wr_mode  = bus_wr && (bus_addr == OFS_MODE);
    wr_event = bus_wr && (bus_addr == OFS_EVENT);
    wr_mask  = bus_wr && (bus_addr == OFS_MASK);
    wr_cmd   = bus_wr && (bus_addr == OFS_CMD);
    wr_tx    = bus_wr && (bus_addr == OFS_TX);
    can_go   = mode_q[MB_EN] && mode_q[MB_MASTER] && !busy;
    go       = can_go && (wr_tx || (wr_cmd && bus_wdata[CMD_GO]));
    go_word  = wr_tx ? bus_wdata : tx_q;
    stop     = wr_mode && !bus_wdata[MB_EN];
    nbits    = char_bits(mode_q[LEN_LO +: LCODE_W]);
  end

  // mode register: full write only while disabled
  always_comb begin
    mode_d = mode_q;
    if (!mode_q[MB_EN]) mode_d = bus_wdata & MODE_KEEP;
    else                mode_d[MB_EN] = bus_wdata[MB_EN];
  end

  // events: completion wins over start and acknowledge
  always_comb begin
    ev_rne_d = ev_rne_q;
    ev_tnf_d = ev_tnf_q;
    if (wr_event && bus_wdata[EV_RNE]) ev_rne_d = 1'b0;
    if (wr_event && bus_wdata[EV_TNF]) ev_tnf_d = 1'b0;
    if (go)                            ev_tnf_d = 1'b0;
    if (done) begin
      ev_rne_d = 1'b1;
      ev_tnf_d = 1'b1;
    end
    irq_d = |({ev_rne_q, ev_tnf_q} & mask_q);
  end

  always_comb begin
    case (bus_addr)
      OFS_MODE:  rd_d = mode_q;
      OFS_EVENT: rd_d = WORD_W'({ev_rne_q, ev_tnf_q}) << EV_TNF;
      OFS_MASK:  rd_d = WORD_W'(mask_q) << EV_TNF;
      OFS_TX:    rd_d = tx_q;
      OFS_RX:    rd_d = rx_q;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      mask_q   <= '0;
      ev_rne_q <= 1'b0;
      ev_tnf_q <= 1'b0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= mode_d;
      if (wr_tx && can_go) tx_q <= bus_wdata;
      if (done) rx_q <= rx_word;
      if (wr_mask) mask_q <= bus_wdata[EV_RNE:EV_TNF];
      ev_rne_q <= ev_rne_d;
      ev_tnf_q <= ev_tnf_d;
      if (bus_rd) rdata_q <= rd_d;
      irq_q <= irq_d;
    end
  end

  spi_rm_baud #(.PMW(PM_W)) baud_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .pm   (mode_q[PM_LO +: PM_W]),
    .slow (mode_q[MB_DIV16]),
    .tick (tick)
  );

  spi_rm_shifter #(.W(WORD_W)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (go),
    .stop      (stop),
    .tick      (tick),
    .start_word(go_word),
    .nbits     (nbits),
    .cpol      (mode_q[MB_CPOL]),
    .cpha      (mode_q[MB_CPHA]),
    .lsb_first (!mode_q[MB_MSB]),
    .loop_en   (mode_q[MB_LOOP]),
    .miso      (miso),
    .busy      (busy),
    .sclk_out  (sclk),
    .mosi_out  (mosi),
    .done      (done),
    .rx_word   (rx_word)
  );

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        sclk,
  input logic        irq,
  input logic        ev_rne,
  input logic        ev_tnf,
  input logic [1:0]  mask,
  input logic [31:0] mode
);
  // R6: idle clock level follows polarity bit
  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == mode[29]));

  // R10: interrupt is the masked events of one cycle earlier
  p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|({ev_rne, ev_tnf} & mask)));

  // R3: fields frozen while enabled
  p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode[24]) |-> (mode[30:25] == $past(mode[30:25]) && mode[23:16] == $past(mode[23:16])));

  // R9: transmit-not-full stays low during a character
  p_tnf_low_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_tnf);

  // R9: completion raises both events
  p_done_events_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ev_rne && ev_tnf));
endmodule

bind spi_regmaster spi_regmaster_chk chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .done  (done),
  .sclk  (sclk),
  .irq   (irq),
  .ev_rne(ev_rne_q),
  .ev_tnf(ev_tnf_q),
  .mask  (mask_q),
  .mode  (mode_q)
);

// File: tb/spi_regmaster_tb_top.sv
module spi_regmaster_tb_top;
  import spi_rm_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        bus_wr = 1'b0, bus_rd = 1'b0, miso = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, irq;

  spi_regmaster dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] m_mode = '0, m_tx = '0, m_rx = '0, m_acc = '0, m_rdexp = '0;
  logic [1:0]  m_mask = '0;
  logic        m_rne = 1'b0, m_tnf = 1'b0, m_busy = 1'b0, m_mosi = 1'b0;
  logic        m_irq = 1'b0, m_rdpend = 1'b0;
  int          m_c = 0;
  logic [31:0] sbits = '0;

  function automatic int m_n();
    return (m_mode[23:20] == 4'd0) ? 32 : int'(m_mode[23:20]) + 1;
  endfunction
  function automatic int m_h();
    int p = int'(m_mode[19:16]) + 1;
    return m_mode[27] ? 32 * p : 2 * p;
  endfunction
  function automatic int m_pos(int j);
    return m_mode[26] ? m_n() - 1 - j : j;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic old_int, old_busy, stop, fin, b;
    int k, j;
    old_int  = |({m_rne, m_tnf} & m_mask);
    old_busy = m_busy;
    fin = 1'b0;
    case (bus_addr)
      OFS_MODE:  m_rdexp = m_mode;
      OFS_EVENT: m_rdexp = {22'd0, m_rne, m_tnf, 8'd0};
      OFS_MASK:  m_rdexp = {22'd0, m_mask, 8'd0};
      OFS_TX:    m_rdexp = m_tx;
      OFS_RX:    m_rdexp = m_rx;
      default:   m_rdexp = '0;
    endcase
    m_rdpend = bus_rd;
    stop = bus_wr && bus_addr == OFS_MODE && !bus_wdata[24];
    if (m_busy && !stop) begin
      m_c++;
      if (m_c % m_h() == 0) begin
        k = m_c / m_h();
        j = (k - 1) / 2;
        b = m_mode[30] ? m_mosi : miso;
        if (k % 2 == 1) begin
          if (m_mode[28]) m_mosi = m_tx[m_pos(j)];
          else            m_acc[m_pos(j)] = b;
        end else begin
          if (m_mode[28])        m_acc[m_pos(j)] = b;
          else if (k < 2*m_n())  m_mosi = m_tx[m_pos(k/2)];
        end
        if (k == 2*m_n()) begin
          m_busy = 1'b0; m_rx = m_acc; fin = 1'b1;
        end
      end
    end
    if (stop) m_busy = 1'b0;
    if (bus_wr) begin
      case (bus_addr)
        OFS_MODE:  if (!m_mode[24]) m_mode = bus_wdata & 32'h7FFF_0000;
                   else m_mode[24] = bus_wdata[24];
        OFS_EVENT: begin
          if (bus_wdata[9]) m_rne = 1'b0;
          if (bus_wdata[8]) m_tnf = 1'b0;
        end
        OFS_MASK:  m_mask = bus_wdata[9:8];
        OFS_CMD, OFS_TX: begin
          if ((bus_addr == OFS_TX || bus_wdata[23]) && m_mode[24] && m_mode[25] && !old_busy) begin
            if (bus_addr == OFS_TX) m_tx = bus_wdata;
            m_busy = 1'b1; m_c = 0; m_acc = '0; m_tnf = 1'b0;
            if (!m_mode[28]) m_mosi = m_tx[m_pos(0)];
          end
        end
        default: ;
      endcase
    end
    if (fin) begin m_rne = 1'b1; m_tnf = 1'b1; end
    m_irq = old_int;
  endtask

  task automatic compare();
    logic es;
    es = m_busy ? (m_mode[29] ^ logic'((m_c / m_h()) % 2)) : m_mode[29];
    chk(sclk == es, "R6 sclk", {31'd0, sclk}, {31'd0, es});
    chk(mosi == m_mosi, "R6 mosi", {31'd0, mosi}, {31'd0, m_mosi});
    chk(irq == m_irq, "R10 irq", {31'd0, irq}, {31'd0, m_irq});
    if (m_rdpend) chk(bus_rdata == m_rdexp, "R2 read data", bus_rdata, m_rdexp);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare();
    miso = m_busy ? sbits[(m_c / m_h()) / 2] : 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1;
    step();
    bus_rd = 1'b0;
    chk(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (m_busy && g < 20000) begin step(); g++; end
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(sclk == 1'b0, "R1 sclk", {31'd0, sclk}, 32'd0);
    chk(mosi == 1'b0, "R1 mosi", {31'd0, mosi}, 32'd0);
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    rd_chk(OFS_MODE, 32'h0, "R1 mode");
    rd_chk(OFS_EVENT, 32'h0, "R1 event");
    rd_chk(OFS_MASK, 32'h0, "R1 mask");
    rd_chk(OFS_TX, 32'h0, "R1 transmit");
    rd_chk(OFS_RX, 32'h0, "R1 receive");
    rd_chk(8'h00, 32'h0, "R2 reserved");

    // R2 / R3 mode write masking and freeze
    wr(OFS_MODE, 32'hFFFF_FFFF);
    rd_chk(OFS_MODE, 32'h7FFF_0000, "R2 mode keep bits");
    wr(OFS_MODE, 32'h0000_0000);
    rd_chk(OFS_MODE, 32'h7EFF_0000, "R3 only enable changes");
    wr(OFS_MODE, 32'h0000_0000);
    rd_chk(OFS_MODE, 32'h0000_0000, "R3 full write when disabled");

    // config A: mode 0, MSB first, 8 bits, PM 0
    wr(OFS_MODE, 32'h0770_0000);
    wr(OFS_MASK, 32'h0000_0300);
    rd_chk(OFS_MASK, 32'h0000_0300, "R2 mask");
    sbits = 32'h0000_0001;
    wr(OFS_TX, 32'h0000_00A5);
    rd_chk(OFS_EVENT, 32'h0, "R9 tnf cleared at start");
    wr(OFS_MODE, 32'h0775_0000);
    rd_chk(OFS_MODE, 32'h0770_0000, "R3 write while enabled");
    wr(OFS_TX, 32'h0000_003C);
    wait_idle();
    rd_chk(OFS_TX, 32'h0000_00A5, "R4 write while busy dropped");
    rd_chk(OFS_EVENT, 32'h0000_0300, "R9 events at end");
    rd_chk(OFS_RX, 32'h0000_0080, "R7 msb-first receive");
    rd_chk(OFS_CMD, 32'h0, "R2 command reads zero");
    chk(irq == 1'b1, "R10 irq set", {31'd0, irq}, 32'd1);
    rd_chk(OFS_EVENT, 32'h0000_0300, "R9 read does not clear");
    wr(OFS_EVENT, 32'h0000_0200);
    rd_chk(OFS_EVENT, 32'h0000_0100, "R9 write one clears");

    // config B: idle high, leading-edge change, LSB first, 5 bits, PM 1
    wr(OFS_MODE, 32'h0);
    wr(OFS_MODE, 32'h3341_0000);
    step();
    chk(sclk == 1'b1, "R6 idle high", {31'd0, sclk}, 32'd1);
    sbits = 32'h0000_000D;
    wr(OFS_TX, 32'h0000_0016);
    repeat (3) step();
    chk(sclk == 1'b1, "R5 before first edge", {31'd0, sclk}, 32'd1);
    step();
    chk(sclk == 1'b0, "R5 first edge", {31'd0, sclk}, 32'd0);
    wait_idle();
    rd_chk(OFS_RX, 32'h0000_000D, "R7 lsb-first 5-bit receive");

    // config C: 32-bit loopback, rne left set
    wr(OFS_MODE, 32'h0);
    wr(OFS_MODE, 32'h4700_0000);
    sbits = 32'hFFFF_FFFF;
    wr(OFS_TX, 32'hDEAD_BEEF);
    wait_idle();
    rd_chk(OFS_RX, 32'hDEAD_BEEF, "R8 loopback 32-bit");
    rd_chk(OFS_EVENT, 32'h0000_0300, "R13 overwrite without overrun");

    // config D: divide-by-16, 4 bits
    wr(OFS_MODE, 32'h0);
    wr(OFS_MODE, 32'h0F30_0000);
    sbits = 32'h0000_0003;
    wr(OFS_TX, 32'h0000_0009);
    repeat (31) step();
    chk(sclk == 1'b0, "R5 slow before first edge", {31'd0, sclk}, 32'd0);
    step();
    chk(sclk == 1'b1, "R5 slow first edge", {31'd0, sclk}, 32'd1);
    wait_idle();
    rd_chk(OFS_RX, 32'h0000_000C, "R7 4-bit receive");

    // abort with idle-high clock
    wr(OFS_EVENT, 32'h0000_0300);
    wr(OFS_MODE, 32'h0);
    wr(OFS_MODE, 32'h2F30_0000);
    wr(OFS_TX, 32'h0000_0005);
    repeat (40) step();
    wr(OFS_MODE, 32'h0);
    chk(sclk == 1'b1, "R11 sclk idle after abort", {31'd0, sclk}, 32'd1);
    repeat (300) step();
    rd_chk(OFS_EVENT, 32'h0, "R11 no events after abort");
    rd_chk(OFS_RX, 32'h0000_000C, "R11 receive unchanged");

    // command strobe resend
    wr(OFS_MODE, 32'h2F30_0000);
    wr(OFS_CMD, 32'h0080_0000);
    rd_chk(OFS_EVENT, 32'h0, "R12 start strobe began");
    wait_idle();
    rd_chk(OFS_EVENT, 32'h0000_0300, "R12 strobe completes");
    rd_chk(OFS_TX, 32'h0000_0005, "R12 transmit kept");

    // master clear: no start
    wr(OFS_MODE, 32'h0);
    wr(OFS_MODE, 32'h0530_0000);
    wr(OFS_TX, 32'h0000_0007);
    repeat (20) step();
    rd_chk(OFS_TX, 32'h0000_0005, "R4 no master no start");
    wr(OFS_MASK, 32'h0);
    repeat (3) step();
    chk(irq == 1'b0, "R10 irq masked", {31'd0, irq}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule